// File: doc/BRIEF.md
# Privileged Instruction Decode Guard

This block sits in the decode stage. Each cycle it takes one pre-decoded instruction class and the code segment selector of the running context. The low two bits of the selector give the current privilege level, where 0 is the most trusted level and 3 the least. If the class is one of the system-control classes and the level is not 0, the block raises a general protection fault and the instruction is never issued. Any other accepted instruction is marked valid to issue. Because the decision is made before execution, a blocked instruction leaves no side effects.

The result is held in one register stage. The fault is a single-cycle pulse, and beside it sits a registered cause code that names the class which was refused. A stall input freezes the stage. A flush input drops whatever the stage holds, including a pending fault. The system-control set is a parameter bit mask indexed by class code.

Top module: `priv_decode_guard`

## Requirements
- R1: The privilege level is `cs_sel_i[1:0]`. Selector bits 15..2 have no effect on `issue_o`, `fault_o` or `cause_o`.
- R2: A privileged class accepted at level 0 gives `issue_o`=1 and `fault_o`=0 in the next cycle. The privileged codes are 4 halt, 5 descriptor-table register load, 6 control register write, 7 port input, 8 port output and 9 model-specific register write.
- R3: A privileged class accepted at level 1, 2 or 3 gives `fault_o`=1 and `issue_o`=0 in the next cycle.
- R4: Class codes 0 to 3 and 10 to 15 give `issue_o`=1 and `fault_o`=0 in the next cycle at every level.
- R5: In the cycle after a faulting instruction is accepted, `cause_o` equals its class code. After an accepted instruction that issues, `cause_o` is 0.
- R6: A cycle with `valid_i`=0, and no stall or flush, gives `issue_o`=0, `fault_o`=0 and `cause_o`=0 in the next cycle.
- R7: A stall cycle without flush keeps `issue_o` and `cause_o` unchanged and drives `fault_o` to 0 in the next cycle. The fault pulse therefore lasts exactly one cycle.
- R8: A flush clears `issue_o`, `fault_o` and `cause_o` in the next cycle. Flush takes priority over stall.
- R9: While `rst_ni` is low, all outputs are 0.
- R10: `issue_o` and `fault_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A decoded instruction is present |
| class_i | input | 4 | Pre-decoded instruction class code |
| cs_sel_i | input | 16 | Active code segment selector |
| stall_i | input | 1 | Hold the registered result |
| flush_i | input | 1 | Drop the registered result |
| issue_o | output | 1 | Instruction may proceed to execution |
| fault_o | output | 1 | General protection fault pulse |
| cause_o | output | 4 | Class code of the refused instruction |

## Verification
The bench uses the default parameters: a 16-bit selector, a 2-bit level and the mask 0x03F0. With these values, all 16 classes at all 4 levels come to only 64 pairs. The bench sweeps every pair directly, then repeats the sweep with random upper selector bits. After that, random runs mix in stalls, flushes and empty cycles, so that held results, back-to-back faults and a flush during a stall all occur.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;
  localparam int CLASS_W = 4;
  localparam int N_CLASS = 1 << CLASS_W;

  typedef enum logic [CLASS_W-1:0] {
    OPC_ALU      = 4'd0,
    OPC_LOAD     = 4'd1,
    OPC_STORE    = 4'd2,
    OPC_BRANCH   = 4'd3,
    OPC_HALT     = 4'd4,
    OPC_TBL_LOAD = 4'd5,
    OPC_CTRL_WR  = 4'd6,
    OPC_PORT_IN  = 4'd7,
    OPC_PORT_OUT = 4'd8,
    OPC_MODEL_WR = 4'd9
  } op_class_e;

  function automatic logic [N_CLASS-1:0] default_priv_mask();
    logic [N_CLASS-1:0] m;
    m = '0;
    m[OPC_HALT]     = 1'b1;
    m[OPC_TBL_LOAD] = 1'b1;
    m[OPC_CTRL_WR]  = 1'b1;
    m[OPC_PORT_IN]  = 1'b1;
    m[OPC_PORT_OUT] = 1'b1;
    m[OPC_MODEL_WR] = 1'b1;
    return m;
  endfunction

  localparam logic [N_CLASS-1:0] PRIV_MASK_DEF = default_priv_mask();
endpackage

// File: rtl/priv_cpl_extract.sv
module priv_cpl_extract #(
  parameter int SEL_W = 16,
  parameter int CPL_W = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CPL_W-1:0] cpl_o,
  output logic             top_level_o
);
  logic unused_sel_hi;
  assign unused_sel_hi = ^sel_i[SEL_W-1:CPL_W];
  assign cpl_o         = sel_i[CPL_W-1:0];
  assign top_level_o   = (cpl_o == '0);
endmodule

// File: rtl/priv_class_lookup.sv
module priv_class_lookup
  import priv_guard_pkg::*;
#(
  parameter logic [N_CLASS-1:0] MASK = PRIV_MASK_DEF
) (
  input  logic [CLASS_W-1:0] class_i,
  output logic               priv_o
);
  logic [N_CLASS-1:0] hit;
  for (genvar k = 0; k < N_CLASS; k++) begin : g_cls
    if (MASK[k]) begin : g_on
      assign hit[k] = (class_i == CLASS_W'(k));
    end else begin : g_off
      assign hit[k] = 1'b0;
    end
  end
  assign priv_o = |hit;
endmodule

// File: rtl/priv_result_reg.sv
module priv_result_reg
  import priv_guard_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               deny_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic               stall_i,
  input  logic               flush_i,
  output logic               issue_o,
  output logic               fault_o,
  output logic [CLASS_W-1:0] cause_o
);
  logic               issue_q, fault_q;
  logic [CLASS_W-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= '0;
    end else if (flush_i) begin
      issue_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= '0;
    end else if (stall_i) begin
      fault_q <= 1'b0;  // pulse ends; issue and cause held
    end else begin
      issue_q <= valid_i & ~deny_i;
      fault_q <= valid_i & deny_i;
      cause_q <= (valid_i & deny_i) ? class_i : '0;
    end
  end

  assign issue_o = issue_q;
  assign fault_o = fault_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/priv_decode_guard.sv
module priv_decode_guard
  import priv_guard_pkg::*;
#(
  parameter int                 SEL_W     = 16,
  parameter int                 CPL_W     = 2,
  parameter logic [N_CLASS-1:0] PRIV_MASK = PRIV_MASK_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic [SEL_W-1:0]   cs_sel_i,
  input  logic               stall_i,
  input  logic               flush_i,
  output logic               issue_o,
  output logic               fault_o,
  output logic [CLASS_W-1:0] cause_o
);
  logic [CPL_W-1:0] cpl;
  logic             at_top, is_priv, deny;

  priv_cpl_extract #(.SEL_W(SEL_W), .CPL_W(CPL_W)) i_cpl (
    .sel_i      (cs_sel_i),
    .cpl_o      (cpl),
    .top_level_o(at_top)
  );

  priv_class_lookup #(.MASK(PRIV_MASK)) i_lookup (
    .class_i(class_i),
    .priv_o (is_priv)
  );

  assign deny = is_priv & ~at_top;

  priv_result_reg i_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .deny_i (deny),
    .class_i(class_i),
    .stall_i(stall_i),
    .flush_i(flush_i),
    .issue_o(issue_o),
    .fault_o(fault_o),
    .cause_o(cause_o)
  );
endmodule

// File: rtl/priv_guard_chk.sv
module priv_guard_chk
  import priv_guard_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int CPL_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [SEL_W-1:0]   cs_sel_i,
  input logic               stall_i,
  input logic               flush_i,
  input logic               issue_o,
  input logic               fault_o,
  input logic [CLASS_W-1:0] cause_o
);
  // R10
  excl_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_o && fault_o));

  // R8
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!issue_o && !fault_o && cause_o == '0));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i) |=> ($stable(issue_o) && $stable(cause_o) && !fault_o));

  // R2
  top_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !stall_i && !flush_i && cs_sel_i[CPL_W-1:0] == '0) |=> issue_o);

  // R6
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !stall_i && !flush_i) |=> (!issue_o && !fault_o && cause_o == '0));

  // R5
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> cause_o != '0);
endmodule

bind priv_decode_guard priv_guard_chk #(.SEL_W(SEL_W), .CPL_W(CPL_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .cs_sel_i(cs_sel_i),
  .stall_i (stall_i),
  .flush_i (flush_i),
  .issue_o (issue_o),
  .fault_o (fault_o),
  .cause_o (cause_o)
);

// File: tb/test_priv_decode_guard.sv
module test_priv_decode_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  class_i = '0;
  logic [15:0] cs_sel_i = '0;
  logic        stall_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        issue_o, fault_o;
  logic [3:0]  cause_o;

  int n_chk = 0, n_fail = 0;
  int e_issue = 0, e_fault = 0, e_cause = 0;
  string force_tag = "";
  bit done = 0;

  always #2 clk_i = ~clk_i;

  priv_decode_guard i_priv_decode_guard (.*);

  function automatic bit is_priv(int c);
    return c >= 4 && c <= 9;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  // advance model over the edge just passed, then compare
  task automatic step_check();
    string tag, ctag;
    int lvl;
    lvl = cs_sel_i[1:0];
    if (flush_i) begin
      e_issue = 0; e_fault = 0; e_cause = 0; tag = "R8"; ctag = "R8";
    end else if (stall_i) begin
      e_fault = 0; tag = "R7"; ctag = "R7";
    end else if (!valid_i) begin
      e_issue = 0; e_fault = 0; e_cause = 0; tag = "R6"; ctag = "R6";
    end else begin
      if (is_priv(class_i) && lvl != 0) begin
        e_issue = 0; e_fault = 1; e_cause = class_i; tag = "R3";
      end else begin
        e_issue = 1; e_fault = 0; e_cause = 0;
        tag = is_priv(class_i) ? "R2" : "R4";
      end
      ctag = "R5";
    end
    if (force_tag != "") begin tag = force_tag; ctag = force_tag; end
    chk(tag, issue_o, e_issue);
    chk(tag, fault_o, e_fault);
    chk(ctag, cause_o, e_cause);
    chk("R10", int'(issue_o & fault_o), 0);
  endtask

  task automatic cyc(bit v, int c, int sel, bit st, bit fl);
    @(posedge clk_i);
    @(negedge clk_i);
    step_check();
    valid_i = v; class_i = 4'(c); cs_sel_i = 16'(sel); stall_i = st; flush_i = fl;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9
    chk("R9", issue_o, 0); chk("R9", fault_o, 0); chk("R9", cause_o, 0);
    valid_i = 1'b1; class_i = 4'd6; cs_sel_i = 16'h3;
    @(negedge clk_i);
    chk("R9", fault_o, 0); chk("R9", cause_o, 0);
    valid_i = 1'b0; rst_ni = 1'b1;
    @(negedge clk_i);
    // exhaustive class x level sweep
    for (int c = 0; c < 16; c++)
      for (int l = 0; l < 4; l++) cyc(1, c, l, 0, 0);
    // R1: upper selector bits randomized
    force_tag = "R1";
    cyc(0, 0, 0, 0, 0);
    for (int c = 0; c < 16; c++)
      for (int l = 0; l < 4; l++) cyc(1, c, ((l == 0 ? 16'hFFFC : $urandom) & 16'hFFFC) | l, 0, 0);
    cyc(0, 0, 0, 0, 0);
    force_tag = "";
    // directed: fault then stalls, then flush during stall
    cyc(1, 7, 16'h0002, 0, 0);
    cyc(1, 1, 0, 1, 0);
    cyc(1, 1, 0, 1, 0);
    cyc(1, 9, 16'h0001, 0, 0);
    cyc(1, 8, 16'h0003, 0, 0);
    cyc(1, 4, 16'h0003, 1, 1);
    cyc(1, 5, 16'h0000, 0, 0);
    cyc(1, 5, 16'h0000, 1, 0);
    cyc(0, 0, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 600; i++)
      cyc(($urandom % 4) != 0, $urandom % 16, $urandom, ($urandom % 4) == 0, ($urandom % 8) == 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule